// File: doc/BRIEF.md
# Isochronous Arbiter Rate Calculator

This block converts display-window bandwidth requests into credit-rate values for a time-sharing memory arbiter. Six window bandwidths (MB/s) arrive as two groups of three. For each group the block forms an effective bandwidth: the number of windows with non-zero bandwidth times the largest bandwidth in the group. It scales that value against the peak memory bandwidth (16 bytes per clock at the base memory frequency) with the factor 281, and clips the result to 255. The two group rates, a fixed camera-ring rate and a fixed secondary-ring rate are then added and halved to give the rate of the parent ring. A grant-decrement value is also produced from the current memory clock and a same-frequency flag.

A one-cycle start pulse captures every input and launches one restoring shift-subtract divider per group. The dividers run in parallel and produce one quotient bit per clock. When the quotients are ready, all outputs are registered together and a one-cycle done pulse is raised. The outputs then hold until the next computation completes.

Top module: `lar_rate_calc`

## Requirements
- R1: After reset, busy and done are low and every rate output and the grant value are zero.
- R2: Group A is windows 0, 1 and 2 (lowest indices of the window bus) and group B is windows 3, 4 and 5. A group's effective bandwidth is the count of its windows with non-zero bandwidth times the largest bandwidth among them.
- R3: Each group rate equals floor(281 × effective bandwidth / (16 × base clock MHz)), clipped to 255. Group A is element 0 of the rate bus.
- R4: A base clock of zero gives a rate of 255 for both groups, whatever the bandwidths.
- R5: The parent ring rate equals floor((rate A + rate B + camera rate + secondary-ring rate) / 2).
- R6: The grant value equals 256 × (2 when the same-frequency flag is 1, else 1) × memory clock MHz, clipped to 511.
- R7: Done is high for exactly one cycle, on the 24th rising edge after the edge that samples start. Busy is high from the edge after start until that same edge.
- R8: A start pulse while busy is ignored, and inputs changed while busy have no effect: results reflect the inputs sampled with the accepted start, and the done edge is not moved.
- R9: Outputs hold their values between done pulses, even when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch pulse, accepted only when idle |
| win_bw_i | input | 6×12 | Window bandwidths in MB/s, index 0 to 5 |
| base_mhz_i | input | 16 | Base memory clock in MHz |
| cam_rate_i | input | 8 | Fixed camera-ring rate |
| ring2_rate_i | input | 8 | Fixed secondary-ring rate |
| mem_mhz_i | input | 16 | Current memory clock in MHz |
| same_freq_i | input | 1 | Same-frequency flag for the grant multiplier |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse when the outputs are updated |
| grp_rate_o | output | 2×8 | Group rates, element 0 is group A |
| ring_rate_o | output | 9 | Parent ring rate |
| grant_dec_o | output | 9 | Grant decrement value |

## Verification
The hardest situation to reach from the ports is a second start and changed operands arriving while the dividers are mid-way through their quotient. From the outside this looks like an ordinary run, and only the results and the done edge reveal a wrong capture. The stimulus reaches it on purpose: on the fifth cycle of a run, the bench changes every input to new random values and pulses start. It then checks that the done edge and all results still match the first operand set. The edges of the divider are also driven directly: a zero base clock, exact saturation, all-zero groups and a single active window.

// File: rtl/lar_pkg.sv
// Package: shared constants and state type for the arbiter rate calculator.
// Assumes rates are 8-bit unsigned credit values.
package lar_pkg;
    localparam int RATE_MUL      = 281;
    localparam int RATE_MAX      = 255;
    localparam int BYTES_SHIFT   = 4;    // 16 bytes per base clock
    localparam int GRANT_UNIT_SH = 8;    // 256 per MHz
    localparam int GRANT_MAX     = 511;
    localparam int GRANT_W       = 9;

    typedef enum logic {
        LAR_IDLE = 1'b0,
        LAR_RUN  = 1'b1
    } lar_state_e;
endpackage

// File: rtl/lar_grp_reduce.sv
// Module: reduces one window group to its effective bandwidth, equal to
// the count of non-zero windows times the largest window bandwidth.
// Assumes unsigned bandwidths; purely combinational.
module lar_grp_reduce #(
    parameter int WIN   = 3,
    parameter int BW_W  = 12,
    localparam int CNT_W = $clog2(WIN + 1),
    localparam int EFF_W = BW_W + CNT_W
) (
    input  logic [WIN-1:0][BW_W-1:0] bw_i,
    output logic [EFF_W-1:0]         eff_o
);
    logic [CNT_W-1:0] act_cnt;
    logic [BW_W-1:0]  peak_bw;

    // Count active windows and track the peak bandwidth.
    always_comb begin
        act_cnt = '0;
        peak_bw = '0;
        for (int i = 0; i < WIN; i++) begin
            if (bw_i[i] != '0) act_cnt = act_cnt + 1'b1;
            if (bw_i[i] > peak_bw) peak_bw = bw_i[i];
        end
        eff_o = EFF_W'(act_cnt) * EFF_W'(peak_bw);
    end
endmodule

// File: rtl/lar_div.sv
// Module: restoring shift-subtract divider, one quotient bit per clock.
// A load starts a division that takes NUM_W steps; fin_o pulses for one
// cycle with the quotient valid. Assumes load only while not running.
// A zero divisor yields an all-ones quotient.
module lar_div #(
    parameter int NUM_W = 23,
    parameter int DEN_W = 20,
    localparam int CNT_W = $clog2(NUM_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic [NUM_W-1:0] quo_o,
    output logic             fin_o
);
    logic             run_q;
    logic [CNT_W-1:0] step_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] shq_q;
    logic [DEN_W:0]   trial;
    logic             take;

    // Trial subtraction for the current quotient bit.
    always_comb begin
        trial = {rem_q, shq_q[NUM_W-1]};
        take  = trial >= {1'b0, den_q};
    end

    // Step the partial remainder and shift the quotient in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            fin_o  <= 1'b0;
            step_q <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            shq_q  <= '0;
        end else if (load_i) begin
            run_q  <= 1'b1;
            fin_o  <= 1'b0;
            step_q <= '0;
            rem_q  <= '0;
            den_q  <= den_i;
            shq_q  <= num_i;
        end else if (run_q) begin
            rem_q  <= take ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
            shq_q  <= {shq_q[NUM_W-2:0], take};
            step_q <= step_q + 1'b1;
            if (step_q == CNT_W'(NUM_W - 1)) begin
                run_q <= 1'b0;
                fin_o <= 1'b1;
            end
        end else begin
            fin_o <= 1'b0;
        end
    end

    assign quo_o = shq_q;

    // R3: a finished division leaves a remainder below a non-zero divisor.
    a_r3_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_o && den_q != '0) |-> (rem_q < den_q));

    // R8: the divisor is not disturbed while a division runs.
    a_r8_den_hold: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> $stable(den_q));
endmodule

// File: rtl/lar_rate_calc.sv
// Module: top of the arbiter rate calculator. Captures inputs on an
// accepted start, runs one divider per display group in parallel, clips
// the rates, forms the halved parent-ring sum and the grant value, and
// registers everything with a one-cycle done pulse.
// Assumes start is ignored while busy.
module lar_rate_calc
    import lar_pkg::*;
#(
    parameter int GROUPS = 2,
    parameter int WIN    = 3,
    parameter int BW_W   = 12,
    parameter int MHZ_W  = 16,
    parameter int RATE_W = 8,
    localparam int SUM_W  = RATE_W + $clog2(GROUPS + 2),
    localparam int RING_W = SUM_W - 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic [GROUPS*WIN-1:0][BW_W-1:0]   win_bw_i,
    input  logic [MHZ_W-1:0]                  base_mhz_i,
    input  logic [RATE_W-1:0]                 cam_rate_i,
    input  logic [RATE_W-1:0]                 ring2_rate_i,
    input  logic [MHZ_W-1:0]                  mem_mhz_i,
    input  logic                              same_freq_i,
    output logic                              busy_o,
    output logic                              done_o,
    output logic [GROUPS-1:0][RATE_W-1:0]     grp_rate_o,
    output logic [RING_W-1:0]                 ring_rate_o,
    output logic [GRANT_W-1:0]                grant_dec_o
);
    localparam int CNT_W   = $clog2(WIN + 1);
    localparam int EFF_W   = BW_W + CNT_W;
    localparam int MUL_W   = $clog2(RATE_MUL + 1);
    localparam int NUM_W   = EFF_W + MUL_W;
    localparam int DEN_W   = MHZ_W + BYTES_SHIFT;
    localparam int GFULL_W = MHZ_W + GRANT_UNIT_SH + 1;

    lar_state_e                  state_q;
    logic                        launch;
    logic [DEN_W-1:0]            den_w;
    logic [GROUPS-1:0]           fin_w;
    logic [GROUPS-1:0][RATE_W-1:0] sat_w;
    logic [RATE_W-1:0]           cam_q;
    logic [RATE_W-1:0]           r2_q;
    logic [MHZ_W-1:0]            mem_q;
    logic                        same_q;
    logic [SUM_W-1:0]            ring_sum;
    logic [GFULL_W-1:0]          grant_full;
    logic [GRANT_W-1:0]          grant_w;

    assign launch = start_i && (state_q == LAR_IDLE);
    assign den_w  = {base_mhz_i, BYTES_SHIFT'(0)};
    assign busy_o = (state_q == LAR_RUN);

    // One reducer, divider and clip per display group.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [EFF_W-1:0] eff;
        logic [NUM_W-1:0] num;
        logic [NUM_W-1:0] quo;

        lar_grp_reduce #(.WIN(WIN), .BW_W(BW_W)) u_red (
            .bw_i  (win_bw_i[g*WIN +: WIN]),
            .eff_o (eff)
        );

        assign num = NUM_W'(eff) * NUM_W'(RATE_MUL);

        lar_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (launch),
            .num_i  (num),
            .den_i  (den_w),
            .quo_o  (quo),
            .fin_o  (fin_w[g])
        );

        assign sat_w[g] = (quo > NUM_W'(RATE_MAX)) ? RATE_W'(RATE_MAX)
                                                   : RATE_W'(quo);
    end

    // Sum all ring contributors for the parent ring rate.
    always_comb begin
        ring_sum = SUM_W'(cam_q) + SUM_W'(r2_q);
        for (int g = 0; g < GROUPS; g++) ring_sum = ring_sum + SUM_W'(sat_w[g]);
    end

    // Grant decrement from the captured memory clock, clipped.
    always_comb begin
        grant_full = GFULL_W'({mem_q, GRANT_UNIT_SH'(0)}) << same_q;
        grant_w    = (grant_full > GFULL_W'(GRANT_MAX)) ? GRANT_W'(GRANT_MAX)
                                                        : GRANT_W'(grant_full);
    end

    // Control, input capture and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= LAR_IDLE;
            done_o      <= 1'b0;
            cam_q       <= '0;
            r2_q        <= '0;
            mem_q       <= '0;
            same_q      <= 1'b0;
            grp_rate_o  <= '0;
            ring_rate_o <= '0;
            grant_dec_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (launch) begin
                state_q <= LAR_RUN;
                cam_q   <= cam_rate_i;
                r2_q    <= ring2_rate_i;
                mem_q   <= mem_mhz_i;
                same_q  <= same_freq_i;
            end else if (state_q == LAR_RUN && (&fin_w)) begin
                state_q     <= LAR_IDLE;
                done_o      <= 1'b1;
                grp_rate_o  <= sat_w;
                ring_rate_o <= RING_W'(ring_sum >> 1);
                grant_dec_o <= grant_w;
            end
        end
    end

    // R7: done lasts a single cycle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: done only ends a run that was busy.
    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R9: outputs hold outside done.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(grp_rate_o) && $stable(ring_rate_o) && $stable(grant_dec_o)));

    // R8: a start while busy neither ends nor restarts the run.
    a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !(&fin_w)) |=> busy_o);
endmodule

// File: tb/tb_lar_rate_calc.sv
// Bench: directed corners plus seeded random runs against a bench model.
module tb_lar_rate_calc;
    localparam int LAT = 24;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start_i;
    logic [5:0][11:0] win_bw_i;
    logic [15:0]      base_mhz_i;
    logic [7:0]       cam_rate_i;
    logic [7:0]       ring2_rate_i;
    logic [15:0]      mem_mhz_i;
    logic             same_freq_i;
    logic             busy_o;
    logic             done_o;
    logic [1:0][7:0]  grp_rate_o;
    logic [8:0]       ring_rate_o;
    logic [8:0]       grant_dec_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    lar_rate_calc dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .win_bw_i(win_bw_i),
        .base_mhz_i(base_mhz_i), .cam_rate_i(cam_rate_i),
        .ring2_rate_i(ring2_rate_i), .mem_mhz_i(mem_mhz_i),
        .same_freq_i(same_freq_i), .busy_o(busy_o), .done_o(done_o),
        .grp_rate_o(grp_rate_o), .ring_rate_o(ring_rate_o),
        .grant_dec_o(grant_dec_o)
    );

    function automatic longint eff_m(input logic [5:0][11:0] w, input int grp);
        longint mx = 0;
        longint n = 0;
        for (int i = 0; i < 3; i++) begin
            if (w[grp*3+i] != 0) n++;
            if (w[grp*3+i] > mx) mx = w[grp*3+i];
        end
        return n * mx;
    endfunction

    function automatic int rate_m(input longint eff, input int base);
        longint q;
        if (base == 0) return 255;
        q = (281 * eff) / (16 * longint'(base));
        return (q > 255) ? 255 : int'(q);
    endfunction

    function automatic int grant_m(input int mhz, input bit same);
        longint g = 256 * longint'(mhz) * (same ? 2 : 1);
        return (g > 511) ? 511 : int'(g);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic set_in(input logic [5:0][11:0] w, input int base, input int cam,
                          input int r2, input int mhz, input bit same);
        win_bw_i     = w;
        base_mhz_i   = 16'(base);
        cam_rate_i   = 8'(cam);
        ring2_rate_i = 8'(r2);
        mem_mhz_i    = 16'(mhz);
        same_freq_i  = same;
    endtask

    // Launch one computation and check every result; disturb mid-run if asked.
    task automatic run_case(input logic [5:0][11:0] w, input int base, input int cam,
                            input int r2, input int mhz, input bit same, input bit disturb);
        int n;
        int ra, rb;
        set_in(w, base, cam, r2, mhz, same);
        ra = rate_m(eff_m(w, 0), base);
        rb = rate_m(eff_m(w, 1), base);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 100) begin
            @(negedge clk);
            n++;
            if (n < LAT) check("R7", "busy during run", int'(busy_o), 1);
            if (disturb && n == 5) begin
                set_in({6{12'($urandom)}}, int'($urandom_range(1, 500)),
                       int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                       int'($urandom_range(0, 3)), 1'($urandom));
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
        end
        check(disturb ? "R8" : "R7", "done latency", n, LAT);
        check("R7", "busy low at done", int'(busy_o), 0);
        check(disturb ? "R8" : "R3", "rate group A", int'(grp_rate_o[0]), ra);
        check(disturb ? "R8" : "R2", "rate group B", int'(grp_rate_o[1]), rb);
        check("R5", "ring rate", int'(ring_rate_o), (ra + rb + cam + r2) / 2);
        check("R6", "grant", int'(grant_dec_o), grant_m(mhz, same));
        @(negedge clk);
        check("R7", "done one cycle", int'(done_o), 0);
        // R9: change inputs without start, outputs must hold
        set_in('0, 1, 0, 0, 0, 1'b0);
        repeat (3) @(negedge clk);
        check("R9", "hold rate A", int'(grp_rate_o[0]), ra);
        check("R9", "hold ring", int'(ring_rate_o), (ra + rb + cam + r2) / 2);
    endtask

    initial begin
        while (cyc < 150000) @(negedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        finish_run();
    end

    initial begin
        logic [5:0][11:0] w;
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        start_i = 1'b0;
        set_in('0, 100, 0, 0, 0, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "busy", int'(busy_o), 0);
        check("R1", "done", int'(done_o), 0);
        check("R1", "rates", int'(grp_rate_o), 0);
        check("R1", "ring", int'(ring_rate_o), 0);
        check("R1", "grant", int'(grant_dec_o), 0);

        // R2: all zero windows give zero rates
        run_case('0, 100, 10, 3, 0, 1'b0, 1'b0);
        // R2: single active window in group A, group B two windows
        w = '0; w[1] = 12'd800; w[3] = 12'd400; w[5] = 12'd100;
        run_case(w, 100, 40, 1, 1, 1'b0, 1'b0);
        // R3: saturation with maximum bandwidths
        run_case({6{12'hFFF}}, 1, 255, 255, 1, 1'b1, 1'b0);
        // R3: just below and above the clip point, base 1
        w = '0; w[0] = 12'd14; w[4] = 12'd15;
        run_case(w, 1, 7, 8, 2, 1'b0, 1'b0);
        // R4: zero base clock
        w = '0; w[2] = 12'd5;
        run_case(w, 0, 0, 1, 0, 1'b0, 1'b0);
        run_case('0, 0, 0, 0, 1, 1'b1, 1'b0);
        // R6: grant corners
        run_case('0, 50, 0, 0, 1, 1'b0, 1'b0);
        run_case('0, 50, 0, 0, 1, 1'b1, 1'b0);
        run_case('0, 50, 0, 0, 2, 1'b0, 1'b0);
        run_case('0, 50, 0, 0, 65535, 1'b1, 1'b0);
        // R8: start and input change while busy
        w = '0; w[0] = 12'd900; w[1] = 12'd300; w[3] = 12'd1200;
        run_case(w, 200, 20, 1, 1, 1'b0, 1'b1);

        // Random runs, some with a disturbance
        for (int k = 0; k < 60; k++) begin
            for (int i = 0; i < 6; i++)
                w[i] = ($urandom_range(0, 3) == 0) ? 12'd0 : 12'($urandom);
            run_case(w, int'($urandom_range(0, 8)) == 0 ? 0 : int'($urandom_range(1, 1200)),
                     int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                     int'($urandom_range(0, 4)), 1'($urandom), 1'(k % 5 == 0));
        end
        finish_run();
    end
endmodule